// File: doc/BRIEF.md
# Pixel Hit Timestamp Recorder

This block is the digital back end of a small array of self-triggering pixels. Each pixel sees a one-bit comparator flag that says a particle deposited charge above threshold. While an acquisition window (a bunch train) is open, a shared bunch-crossing counter advances on every crossing tick. A pixel whose flag rises stores the counter value in a small local memory of timestamps.

When the window closes, a sparse scanner walks the array and emits one record for every stored timestamp. Each record holds the pixel column, the pixel row, the stored time and that pixel's overflow flag. Pixels with nothing stored produce no output. Records leave on a valid/ready stream. After the last pixel the block clears every memory and flag. It then gives a one-cycle done pulse and becomes ready for the next window.

Top module: `pixel_hit_recorder`

## Requirements
- R1: After reset, `outValid` and `scanDone` are low and every pixel memory is empty.
- R2: Hit flags are recorded only while a window is open. A window opens on the second rising clock edge after `trainActive` is seen high in the idle state, and recording stops in the cycle where `trainActive` is low. Flags raised before a window or during readout never appear in the output.
- R3: The stored time is the number of `bxTick` pulses seen since the window opened: 0 for the first crossing. It is a TS_W-bit value (14 bits by default) that covers more than 3000 crossings.
- R4: Each pixel holds up to DEPTH (default 4) timestamps, and they are read out oldest first.
- R5: A hit on a pixel that already holds DEPTH entries is dropped and sets a sticky overflow flag. `outOvf` is 1 on every record of that pixel and 0 on the records of other pixels.
- R6: Any number of flag assertions on one pixel between two `bxTick` pulses produce exactly one stored entry.
- R7: Readout is sparse and row-major, starting at pixel index 0. Pixel index p = y*COLS + x, with `outX` = p mod COLS and `outY` = p div COLS, and `hitIn[p]` belongs to that pixel. Every entry of one pixel is sent before the next pixel, and pixels with no entry send nothing.
- R8: While `outValid` is high and `outReady` is low, the record on `outX`, `outY`, `outTime` and `outOvf` is held unchanged and `outValid` stays high.
- R9: After the last record is accepted, `scanDone` is high for exactly one cycle. All memories and overflow flags are then empty, so the next window reports only its own hits. A window with no hits produces no records, only the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hitIn | input | COLS*ROWS | Per-pixel comparator flag, bit p is pixel p |
| trainActive | input | 1 | High while the acquisition window is open |
| bxTick | input | 1 | One-cycle pulse per bunch crossing |
| outReady | input | 1 | Consumer accepts the current record |
| outValid | output | 1 | A record is presented |
| outX | output | clog2(COLS) | Pixel column of the record |
| outY | output | clog2(ROWS) | Pixel row of the record |
| outTime | output | TS_W | Stored bunch-crossing number |
| outOvf | output | 1 | Overflow flag of the pixel |
| scanDone | output | 1 | One-cycle pulse at the end of readout |

## Verification
The bench sends repeated flag pulses within one crossing. A design that stores every edge would fill memories early and raise false overflows. It drives some pixels past DEPTH hits. A wrong design would overwrite old entries or fail to flag the loss. It raises flags before the window opens and during a stalled readout. A leaky design would report them in the next readout. It runs a long window to check a crossing number near 3000, which exposes a narrow counter. It also throttles `outReady`, so a scanner that moves on without a handshake would skip or repeat records.

// File: rtl/phr_pkg.sv
package phr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRAIN,
    ST_SCAN,
    ST_DONE
  } phrState_t;

  typedef struct packed {
    logic recordEn;   // pixels may capture hits this cycle
    logic bxClear;    // restart the crossing counter
    logic clearAll;   // wipe all memories and flags
  } ctlStrobes_t;

endpackage

// File: rtl/phr_pixels.sv
module phr_pixels
  import phr_pkg::*;
#(
  parameter int NPIX  = 16,
  parameter int DEPTH = 4,
  parameter int TS_W  = 14,
  localparam int PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       ctl,
  input  logic [NPIX-1:0]   hitIn,
  input  logic              bxTick,
  input  logic [PIX_W-1:0]  selPix,
  input  logic [ENT_W-1:0]  selEntry,
  output logic [CNT_W-1:0]  selCount,
  output logic [TS_W-1:0]   selTime,
  output logic              selOvf
);

  logic [TS_W-1:0]  bxCount;
  logic [CNT_W-1:0] cnt    [NPIX];
  logic [NPIX-1:0]  ovf;
  logic [NPIX-1:0]  seen;
  logic [TS_W-1:0]  memArr [NPIX][DEPTH];
  logic [NPIX-1:0]  accept;

  // shared crossing counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      bxCount <= '0;
    else if (ctl.bxClear)            bxCount <= '0;
    else if (ctl.recordEn && bxTick) bxCount <= bxCount + 1'b1;
  end

  always_comb begin
    for (int p = 0; p < NPIX; p++)
      accept[p] = ctl.recordEn && hitIn[p] && !seen[p];
  end

  // per-pixel occupancy, overflow and one-entry-per-crossing flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIX; p++) cnt[p] <= '0;
      ovf  <= '0;
      seen <= '0;
    end else if (ctl.clearAll) begin
      for (int p = 0; p < NPIX; p++) cnt[p] <= '0;
      ovf  <= '0;
      seen <= '0;
    end else if (ctl.recordEn) begin
      for (int p = 0; p < NPIX; p++) begin
        if (accept[p]) begin
          if (cnt[p] < CNT_W'(DEPTH)) cnt[p] <= cnt[p] + 1'b1;
          else                        ovf[p] <= 1'b1;
        end
        seen[p] <= bxTick ? 1'b0 : (seen[p] | hitIn[p]);
      end
    end
  end

  // timestamp storage, no reset needed
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPIX; p++) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (accept[p] && cnt[p] == CNT_W'(e)) memArr[p][e] <= bxCount;
      end
    end
  end

  assign selCount = cnt[selPix];
  assign selTime  = memArr[selPix][selEntry];
  assign selOvf   = ovf[selPix];

  // ---------------- assertions ----------------
  logic [NPIX*CNT_W-1:0] cntFlat;
  always_comb begin
    for (int p = 0; p < NPIX; p++) cntFlat[p*CNT_W +: CNT_W] = cnt[p];
  end

  // R2: occupancy cannot move while recording is closed
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.recordEn && !ctl.clearAll) |=> ($stable(cntFlat) && $stable(ovf)));

  // R9: clearing empties everything
  p_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clearAll |=> (cntFlat == '0 && ovf == '0));

  generate
    for (genvar g = 0; g < NPIX; g++) begin : g_pixChk
      // R4: never more than DEPTH entries
      p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[g] <= CNT_W'(DEPTH));
      // R5: overflow only when full, and sticky until cleared
      p_ovf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[g] |-> (cnt[g] == CNT_W'(DEPTH)));
      p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[g] && !ctl.clearAll) |=> ovf[g]);
    end
  endgenerate

endmodule

// File: rtl/phr_ctrl.sv
module phr_ctrl
  import phr_pkg::*;
#(
  parameter int COLS  = 4,
  parameter int ROWS  = 4,
  parameter int DEPTH = 4,
  localparam int NPIX  = COLS * ROWS,
  localparam int PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int X_W   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int Y_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trainActive,
  input  logic              outReady,
  input  logic [CNT_W-1:0]  selCount,
  output ctlStrobes_t       ctl,
  output logic [PIX_W-1:0]  selPix,
  output logic [ENT_W-1:0]  selEntry,
  output logic              outValid,
  output logic [X_W-1:0]    outX,
  output logic [Y_W-1:0]    outY,
  output logic              scanDone
);

  phrState_t        state;
  logic [X_W-1:0]   xCnt;
  logic [Y_W-1:0]   yCnt;
  logic [ENT_W-1:0] eCnt;
  logic             inScan, lastEntry, pixDone, lastPix, lastCol;

  always_comb begin
    inScan    = (state == ST_SCAN);
    outValid  = inScan && (selCount != '0);
    lastEntry = ((CNT_W'(eCnt) + CNT_W'(1)) == selCount);
    pixDone   = inScan && ((selCount == '0) || (outReady && lastEntry));
    lastCol   = (xCnt == X_W'(COLS - 1));
    lastPix   = lastCol && (yCnt == Y_W'(ROWS - 1));
    ctl.recordEn = (state == ST_TRAIN) && trainActive;
    ctl.bxClear  = (state == ST_IDLE) && trainActive;
    ctl.clearAll = (state == ST_DONE);
    scanDone     = (state == ST_DONE);
  end

  assign selPix   = PIX_W'(int'(yCnt) * COLS + int'(xCnt));
  assign selEntry = eCnt;
  assign outX     = xCnt;
  assign outY     = yCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      xCnt  <= '0;
      yCnt  <= '0;
      eCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (trainActive) state <= ST_TRAIN;
        ST_TRAIN: if (!trainActive) begin
                    state <= ST_SCAN;
                    xCnt  <= '0;
                    yCnt  <= '0;
                    eCnt  <= '0;
                  end
        ST_SCAN:  if (pixDone) begin
                    eCnt <= '0;
                    if (lastPix) state <= ST_DONE;
                    else if (lastCol) begin
                      xCnt <= '0;
                      yCnt <= yCnt + 1'b1;
                    end else xCnt <= xCnt + 1'b1;
                  end else if (outValid && outReady) begin
                    eCnt <= eCnt + 1'b1;
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // R8: stalled record holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outX) && $stable(outY)
                                 && $stable(selEntry)));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |=> !scanDone);

  // R2: no output while the window records
  p_no_out_in_train_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.recordEn |-> !outValid);

  // R7: a record is only presented for a pixel that holds entries
  p_valid_has_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (CNT_W'(selEntry) < selCount));

endmodule

// File: rtl/pixel_hit_recorder.sv
module pixel_hit_recorder
  import phr_pkg::*;
#(
  parameter int COLS  = 4,
  parameter int ROWS  = 4,
  parameter int DEPTH = 4,
  parameter int TS_W  = 14,
  localparam int NPIX  = COLS * ROWS,
  localparam int PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int X_W   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int Y_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIX-1:0]  hitIn,
  input  logic             trainActive,
  input  logic             bxTick,
  input  logic             outReady,
  output logic             outValid,
  output logic [X_W-1:0]   outX,
  output logic [Y_W-1:0]   outY,
  output logic [TS_W-1:0]  outTime,
  output logic             outOvf,
  output logic             scanDone
);

  ctlStrobes_t      ctl;
  logic [PIX_W-1:0] selPix;
  logic [ENT_W-1:0] selEntry;
  logic [CNT_W-1:0] selCount;

  phr_ctrl #(.COLS(COLS), .ROWS(ROWS), .DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .trainActive (trainActive),
    .outReady    (outReady),
    .selCount    (selCount),
    .ctl         (ctl),
    .selPix      (selPix),
    .selEntry    (selEntry),
    .outValid    (outValid),
    .outX        (outX),
    .outY        (outY),
    .scanDone    (scanDone)
  );

  phr_pixels #(.NPIX(NPIX), .DEPTH(DEPTH), .TS_W(TS_W)) u_pix (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .hitIn    (hitIn),
    .bxTick   (bxTick),
    .selPix   (selPix),
    .selEntry (selEntry),
    .selCount (selCount),
    .selTime  (outTime),
    .selOvf   (outOvf)
  );

endmodule

// File: tb/sim_pixel_hit_recorder.sv
`timescale 1ns/1ps
module sim_pixel_hit_recorder;

  localparam int COLS = 4, ROWS = 4, DEPTH = 4, TS_W = 14;
  localparam int NPIX = COLS * ROWS;

  logic clk = 0, rst_n = 0;
  logic [NPIX-1:0] hitIn = '0;
  logic trainActive = 0, bxTick = 0, outReady = 0;
  logic outValid, outOvf, scanDone;
  logic [1:0] outX, outY;
  logic [TS_W-1:0] outTime;

  always #10 clk = ~clk;

  pixel_hit_recorder #(.COLS(COLS), .ROWS(ROWS), .DEPTH(DEPTH), .TS_W(TS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .hitIn(hitIn), .trainActive(trainActive),
    .bxTick(bxTick), .outReady(outReady), .outValid(outValid), .outX(outX),
    .outY(outY), .outTime(outTime), .outOvf(outOvf), .scanDone(scanDone));

  int checks = 0, errors = 0;
  int expCnt [NPIX];
  int expTs  [NPIX][DEPTH];
  bit expOvf [NPIX];
  bit seen   [NPIX];
  int bxNow;
  bit inTrain;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int p = 0; p < NPIX; p++) begin
      expCnt[p] = 0; expOvf[p] = 0; seen[p] = 0;
    end
    bxNow = 0;
  endtask

  task automatic pulseHits(input logic [NPIX-1:0] m);
    hitIn = m;
    if (inTrain) begin
      for (int p = 0; p < NPIX; p++) begin
        if (m[p] && !seen[p]) begin
          seen[p] = 1;
          if (expCnt[p] < DEPTH) begin
            expTs[p][expCnt[p]] = bxNow;
            expCnt[p]++;
          end else expOvf[p] = 1;
        end
      end
    end
    @(negedge clk);
    hitIn = '0;
  endtask

  task automatic tick();
    bxTick = 1;
    @(negedge clk);
    bxTick = 0;
    bxNow++;
    for (int p = 0; p < NPIX; p++) seen[p] = 0;
  endtask

  task automatic startTrain();
    clearModel();
    trainActive = 1;
    @(negedge clk);
    @(negedge clk);
    inTrain = 1;
  endtask

  task automatic endTrain();
    trainActive = 0;
    inTrain = 0;
    @(negedge clk);
  endtask

  // collect one readout; stallMode throttles ready, junkHits drives flags during scan
  task automatic collect(input bit stallMode, input bit junkHits);
    int expP = 0, expE = 0, cyc = 0;
    bit stalled = 0;
    int sX = 0, sY = 0, sT = 0, sO = 0;
    bit done = 0;
    while (expP < NPIX && expCnt[expP] == 0) expP++;
    if (junkHits) hitIn = '1;
    while (!done) begin
      outReady = stallMode ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (stalled) begin
        chk(outValid === 1'b1, "R8 valid held", int'(outValid), 1);
        chk(int'(outX) == sX && int'(outY) == sY, "R8 xy held",
            int'(outY) * COLS + int'(outX), sY * COLS + sX);
        chk(int'(outTime) == sT && int'(outOvf) == sO, "R8 time held", int'(outTime), sT);
      end
      stalled = 0;
      if (scanDone) begin
        done = 1;
        chk(outValid == 0, "R9 no valid at done", int'(outValid), 0);
        chk(expP == NPIX, "R7 all records emitted", expP, NPIX);
      end else if (outValid && !outReady) begin
        stalled = 1;
        sX = int'(outX); sY = int'(outY); sT = int'(outTime); sO = int'(outOvf);
      end else if (outValid && outReady) begin
        if (expP >= NPIX) begin
          chk(0, "R7 unexpected record", int'(outY) * COLS + int'(outX), -1);
        end else begin
          chk(int'(outX) == expP % COLS, "R7 x", int'(outX), expP % COLS);
          chk(int'(outY) == expP / COLS, "R7 y", int'(outY), expP / COLS);
          chk(int'(outTime) == expTs[expP][expE], "R3 R4 time", int'(outTime), expTs[expP][expE]);
          chk(outOvf == expOvf[expP], "R5 overflow flag", int'(outOvf), int'(expOvf[expP]));
          expE++;
          if (expE == expCnt[expP]) begin
            expE = 0;
            expP++;
            while (expP < NPIX && expCnt[expP] == 0) expP++;
          end
        end
      end
      cyc++;
      @(negedge clk);
    end
    hitIn = '0;
    outReady = 0;
    #1;
    chk(scanDone == 0, "R9 done single cycle", int'(scanDone), 0);
    chk(outValid == 0, "R9 idle after done", int'(outValid), 0);
    clearModel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearModel();
    inTrain = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(outValid == 0, "R1 reset valid", int'(outValid), 0);
    chk(scanDone == 0, "R1 reset done", int'(scanDone), 0);

    // R2: flags before the window are ignored
    pulseHits(16'h0020);
    pulseHits(16'hFFFF);

    // Train 1: directed corner cases
    startTrain();
    pulseHits(16'h0009);                 // pixels 0 and 3 at bx 0
    tick(); tick();
    pulseHits(16'h0028);                 // pixels 3, 5 at bx 2
    pulseHits(16'h0020);                 // R6 repeated within crossing
    pulseHits(16'h0020);
    for (int c = 0; c < 6; c++) begin    // R5 pixel 15 six crossings, R4 pixel 9 four
      pulseHits(c < 4 ? 16'h8200 : 16'h8000);
      tick();
    end
    endTrain();
    collect(0, 0);

    // Train 2: sweep all pixels, doubled pulses, long window
    startTrain();
    for (int c = 0; c < 12; c++) begin
      logic [NPIX-1:0] m;
      for (int p = 0; p < NPIX; p++) m[p] = (c % (p + 2) == 0);
      pulseHits(m);
      pulseHits(m);                       // R6 second assertion same crossing
      tick();
    end
    while (bxNow < 2999) tick();
    pulseHits(16'h4000);                  // R3 wide timestamp 2999 on pixel 14
    endTrain();
    collect(1, 1);                        // R8 stalls, R2 flags during scan

    // Train 3: empty window, nothing from earlier trains or scan-time flags (R9, R2)
    startTrain();
    tick(); tick();
    endTrain();
    collect(1, 0);

    // Train 4: single hit in last pixel, sparse skip of all others (R7)
    startTrain();
    tick();
    pulseHits(16'h8000);
    endTrain();
    collect(0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule